// File: doc/BRIEF.md
# Six-Source Two-Level Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Six sources feed it: two external request pins, overflow flags from two basic timers, a combined request from a third timer, and a serial-port flag. Software configures an enable register and a priority register through a simple write port. The controller then presents one vectored request at a time to the core, together with the source index, the vector address and the level the request belongs to.

The core accepts a request with a one-cycle acknowledge and signals the end of a service routine with a return strobe. The controller keeps one "in service" bit per priority level. These bits decide which requests may interrupt the running routine. Flags that hardware owns are cleared on acknowledge: the two timer overflow flags, and an external flag when that pin is set to edge mode. Flags that software owns are left alone.

Top module: `irq_ctrl_top`

## Requirements
- R1: After a synchronous reset, the enable and priority registers read 0, no request is presented, no level is in service, and the timer and external flags read 0.
- R2: Writing the enable register (select 0) stores source enables in bits 0 to 5 and the global enable in bit 7. Bit 6 always reads 0 and ignores writes. Writing the priority register (select 1) stores bits 0 to 5, and bits 7:6 read 0.
- R3: A source raises a request only when both its own enable bit and the global enable bit are 1.
- R4: Source indices are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. When several requests are eligible at the same level, the lowest index is presented.
- R5: Any eligible request whose priority bit is 1 (high level) is presented before every low-level request, whatever their indices.
- R6: While a low-level routine is in service, only high-level requests are presented. While a high-level routine is in service, nothing is presented.
- R7: A presented request keeps its index and level until the core acknowledges it, even if its enable bit is cleared in the meantime. The acknowledge withdraws the request and marks its level as in service in the following cycle.
- R8: A return strobe clears the high in-service bit if it is set, and otherwise clears the low bit. A return strobe with nothing in service has no effect.
- R9: A timer 0 or timer 1 set pulse in cycle c makes that timer's flag read 1 from cycle c+1, and its request can first be presented in cycle c+2. A timer 2 flag that is high in cycle c can be presented from cycle c+1.
- R10: The timer 2 request is the OR of its overflow flag and its event flag. Acknowledging it clears neither flag.
- R11: Acknowledging index 1 or 3 clears that timer's flag. Acknowledging an edge-mode external request clears its flag. Level-mode external requests and the serial request are not cleared and are presented again after the return.
- R12: In edge mode, a rising edge on the external pin (after a one-register synchroniser) sets the external flag, and a pin that is held high does not set it again. In level mode the request follows the synchronised pin and the flag reads 0.
- R13: The vector address equals 0x0003 + 8 × index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects enable register, 1 selects priority register |
| cfg_wdata | input | 8 | Write data |
| ie_rd | output | 8 | Enable register contents |
| ip_rd | output | 8 | Priority register contents |
| ext_pin | input | 2 | External request pins, active high |
| ext_edge | input | 2 | Per-pin mode: 1 edge, 0 level |
| tmr_pulse | input | 2 | Set pulses for the timer 0 / timer 1 overflow flags |
| t2_ovf | input | 1 | Timer 2 overflow flag (held by the timer) |
| t2_evt | input | 1 | Timer 2 external-event flag (held by the timer) |
| ser_flag | input | 1 | Serial-port request flag |
| cpu_ack | input | 1 | Core accepts the presented request |
| cpu_reti | input | 1 | Core returns from a service routine |
| irq_req | output | 1 | Vectored request presented |
| irq_idx | output | 3 | Index of the presented source |
| irq_hi | output | 1 | Presented request is high level |
| irq_vec | output | 16 | Vector address |
| act_level | output | 2 | In-service bits: bit 1 high level, bit 0 low level |
| tmr_flag | output | 2 | Timer 0 / timer 1 overflow flags |
| ext_flag | output | 2 | External edge flags |

## Verification
The bench builds the block with its default parameters: a 16-bit vector, base 3, stride 8. With these values every vector address can be predicted from the index alone. A behavioural model is compared with the block on every clock. Directed sequences exercise the following cases:
- the one-cycle polling skew between the timer 0 flag and the timer 2 flag, so a later-index source wins because an earlier one is not yet visible;
- two-level nesting, from entry through both returns;
- a request held while its enable is withdrawn;
- the difference in clearing between edge-mode and level-mode external requests.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NSRC  = 6;
  localparam int NPAIR = 2;
  localparam int IDX_W = $clog2(NSRC);
  localparam int IDX_SER = 4;
  localparam int IDX_T2  = 5;
  localparam int GLOBAL_BIT = 7;

  function automatic logic [IDX_W-1:0] ext_index(input int p);
    return IDX_W'(2 * p);
  endfunction

  function automatic logic [IDX_W-1:0] tmr_index(input int p);
    return IDX_W'(2 * p + 1);
  endfunction
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags
  import irq_ctrl_pkg::*;
#(
  parameter int PAIRS = NPAIR
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PAIRS-1:0]   ext_pin,
  input  logic [PAIRS-1:0]   ext_edge,
  input  logic [PAIRS-1:0]   tmr_pulse,
  input  logic               ack_fire,
  input  logic [IDX_W-1:0]   ack_idx,
  output logic [PAIRS-1:0]   ext_req,
  output logic [PAIRS-1:0]   ext_flag,
  output logic [PAIRS-1:0]   tmr_flag
);
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic sync_q, prev_q, eflag_q, tflag_q;
    logic clr_ext, clr_tmr;

    assign clr_ext = ack_fire && (ack_idx == ext_index(p));
    assign clr_tmr = ack_fire && (ack_idx == tmr_index(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q  <= 1'b0;
        prev_q  <= 1'b0;
        eflag_q <= 1'b0;
        tflag_q <= 1'b0;
      end else begin
        sync_q <= ext_pin[p];
        prev_q <= sync_q;
        if (!ext_edge[p])             eflag_q <= 1'b0;
        else if (sync_q && !prev_q)   eflag_q <= 1'b1;
        else if (clr_ext)             eflag_q <= 1'b0;
        if (tmr_pulse[p])             tflag_q <= 1'b1;
        else if (clr_tmr)             tflag_q <= 1'b0;
      end
    end

    assign ext_req[p]  = ext_edge[p] ? eflag_q : sync_q;
    assign ext_flag[p] = eflag_q;
    assign tmr_flag[p] = tflag_q;

    assert_tmr_set_R9: assert property (@(posedge clk) disable iff (rst)
      tmr_pulse[p] |=> tflag_q);
    assert_tmr_clear_R11: assert property (@(posedge clk) disable iff (rst)
      (ack_fire && ack_idx == tmr_index(p) && !tmr_pulse[p]) |=> !tflag_q);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctrl_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     enab,
  input  logic [N-1:0]     prio,
  input  logic [1:0]       act,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);
  logic [N-1:0] cand_hi, cand_lo;

  always_comb begin
    cand_hi = pend & enab & prio  & {N{~act[1]}};
    cand_lo = pend & enab & ~prio & {N{~act[1] & ~act[0]}};
    found = 1'b0;
    idx   = '0;
    hi    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_lo[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        hi    = 1'b0;
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_hi[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        hi    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       ack_fire,
  input  logic       ack_hi,
  input  logic       reti,
  output logic [1:0] act
);
  logic [1:0] act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (reti) begin
      if (act_q[1]) act_d[1] = 1'b0;
      else          act_d[0] = 1'b0;
    end
    if (ack_fire) act_d[ack_hi] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= 2'b00;
    else     act_q <= act_d;
  end

  assign act = act_q;

  assert_ack_marks_R7: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> ($past(ack_hi) ? act_q[1] : act_q[0]));
  assert_reti_nested_R8: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack_fire && act_q == 2'b11) |=> act_q == 2'b01);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       ie_rd,
  output logic [7:0]       ip_rd,
  input  logic [1:0]       ext_pin,
  input  logic [1:0]       ext_edge,
  input  logic [1:0]       tmr_pulse,
  input  logic             t2_ovf,
  input  logic             t2_evt,
  input  logic             ser_flag,
  input  logic             cpu_ack,
  input  logic             cpu_reti,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_idx,
  output logic             irq_hi,
  output logic [VEC_W-1:0] irq_vec,
  output logic [1:0]       act_level,
  output logic [1:0]       tmr_flag,
  output logic [1:0]       ext_flag
);
  logic [7:0]       ie_q, ip_q;
  logic [NPAIR-1:0] ext_req;
  logic [NSRC-1:0]  pend, enab;
  logic             pick_found, pick_hi, ack_fire;
  logic [IDX_W-1:0] pick_idx;
  logic             req_q, hi_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 8'h00;
      ip_q <= 8'h00;
    end else if (cfg_we) begin
      if (!cfg_sel) ie_q <= {cfg_wdata[7], 1'b0, cfg_wdata[5:0]};
      else          ip_q <= {2'b00, cfg_wdata[5:0]};
    end
  end

  assign ack_fire = req_q && cpu_ack;

  irq_src_flags #(.PAIRS(NPAIR)) u_flags (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_edge(ext_edge),
    .tmr_pulse(tmr_pulse), .ack_fire(ack_fire), .ack_idx(idx_q),
    .ext_req(ext_req), .ext_flag(ext_flag), .tmr_flag(tmr_flag)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_map
    assign pend[2*p]     = ext_req[p];
    assign pend[2*p + 1] = tmr_flag[p];
  end
  assign pend[IDX_SER] = ser_flag;
  assign pend[IDX_T2]  = t2_ovf | t2_evt;
  assign enab = ie_q[NSRC-1:0] & {NSRC{ie_q[GLOBAL_BIT]}};

  irq_pick #(.N(NSRC)) u_pick (
    .pend(pend), .enab(enab), .prio(ip_q[NSRC-1:0]), .act(act_level),
    .found(pick_found), .idx(pick_idx), .hi(pick_hi)
  );

  irq_level_track u_level (
    .clk(clk), .rst(rst), .ack_fire(ack_fire), .ack_hi(hi_q),
    .reti(cpu_reti), .act(act_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      idx_q <= '0;
      hi_q  <= 1'b0;
      vec_q <= VEC_W'(VEC_BASE);
    end else if (ack_fire) begin
      req_q <= 1'b0;
    end else if (!req_q && pick_found) begin
      req_q <= 1'b1;
      idx_q <= pick_idx;
      hi_q  <= pick_hi;
      vec_q <= VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(pick_idx);
    end
  end

  assign irq_req = req_q;
  assign irq_idx = idx_q;
  assign irq_hi  = hi_q;
  assign irq_vec = vec_q;
  assign ie_rd   = ie_q;
  assign ip_rd   = ip_q;

  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (req_q && !cpu_ack) |=> (req_q && $stable(idx_q) && $stable(hi_q)));
  assert_no_same_level_R6: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (!act_level[1] && (hi_q || !act_level[0])));
  assert_global_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(ie_q[GLOBAL_BIT]));
endmodule

// File: tb/irq_ctrl_top_bench.sv
module irq_ctrl_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic [1:0] ext_pin = 0, ext_edge = 0, tmr_pulse = 0;
  logic t2_ovf = 0, t2_evt = 0, ser_flag = 0, cpu_ack = 0, cpu_reti = 0;
  logic [7:0] ie_rd, ip_rd;
  logic irq_req, irq_hi;
  logic [2:0] irq_idx;
  logic [15:0] irq_vec;
  logic [1:0] act_level, tmr_flag, ext_flag;

  int n_chk = 0, n_err = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_ctrl_top u_irq_ctrl_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ie_rd(ie_rd), .ip_rd(ip_rd), .ext_pin(ext_pin), .ext_edge(ext_edge),
    .tmr_pulse(tmr_pulse), .t2_ovf(t2_ovf), .t2_evt(t2_evt), .ser_flag(ser_flag),
    .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .irq_req(irq_req), .irq_idx(irq_idx),
    .irq_hi(irq_hi), .irq_vec(irq_vec), .act_level(act_level),
    .tmr_flag(tmr_flag), .ext_flag(ext_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [7:0] m_ie, m_ip;
  bit m_es[2], m_ep[2], m_ef[2], m_tf[2], m_act[2];
  bit m_req, m_hi;
  int m_idx;

  always @(posedge clk) begin
    bit p[6];
    bit found, nhi, fire, nedge;
    int nidx;
    if (rst) begin
      m_ie = 0; m_ip = 0; m_req = 0; m_hi = 0; m_idx = 0;
      for (int k = 0; k < 2; k++) begin
        m_es[k] = 0; m_ep[k] = 0; m_ef[k] = 0; m_tf[k] = 0; m_act[k] = 0;
      end
    end else begin
      p[0] = ext_edge[0] ? m_ef[0] : m_es[0];
      p[1] = m_tf[0];
      p[2] = ext_edge[1] ? m_ef[1] : m_es[1];
      p[3] = m_tf[1];
      p[4] = ser_flag;
      p[5] = t2_ovf | t2_evt;
      found = 0; nhi = 0; nidx = 0;
      if (!m_act[1])
        for (int i = 0; i < 6; i++)
          if (!found && p[i] && m_ie[i] && m_ie[7] && m_ip[i]) begin
            found = 1; nhi = 1; nidx = i;
          end
      if (!found && !m_act[1] && !m_act[0])
        for (int i = 0; i < 6; i++)
          if (!found && p[i] && m_ie[i] && m_ie[7] && !m_ip[i]) begin
            found = 1; nhi = 0; nidx = i;
          end
      fire = m_req && cpu_ack;
      for (int k = 0; k < 2; k++) begin
        nedge = m_es[k] && !m_ep[k];
        if (!ext_edge[k]) m_ef[k] = 0;
        else if (nedge) m_ef[k] = 1;
        else if (fire && m_idx == 2 * k) m_ef[k] = 0;
        if (tmr_pulse[k]) m_tf[k] = 1;
        else if (fire && m_idx == 2 * k + 1) m_tf[k] = 0;
        m_ep[k] = m_es[k];
        m_es[k] = ext_pin[k];
      end
      if (cpu_reti) begin
        if (m_act[1]) m_act[1] = 0;
        else m_act[0] = 0;
      end
      if (fire) m_act[m_hi] = 1;
      if (fire) m_req = 0;
      else if (!m_req && found) begin
        m_req = 1; m_idx = nidx; m_hi = nhi;
      end
      if (cfg_we) begin
        if (!cfg_sel) m_ie = {cfg_wdata[7], 1'b0, cfg_wdata[5:0]};
        else m_ip = {2'b00, cfg_wdata[5:0]};
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(irq_req == m_req, "R4 irq_req vs model", irq_req, m_req);
      if (m_req) begin
        chk(irq_idx == 3'(m_idx), "R4 irq_idx vs model", irq_idx, m_idx);
        chk(irq_hi == m_hi, "R5 irq_hi vs model", irq_hi, m_hi);
        chk(irq_vec == 16'(3 + 8 * m_idx), "R13 irq_vec vs model", irq_vec, 3 + 8 * m_idx);
      end
      chk(act_level == {m_act[1], m_act[0]}, "R6 act_level vs model", act_level, {m_act[1], m_act[0]});
      chk(ie_rd == m_ie, "R2 ie_rd vs model", ie_rd, m_ie);
      chk(ip_rd == m_ip, "R2 ip_rd vs model", ip_rd, m_ip);
      chk(tmr_flag == {m_tf[1], m_tf[0]}, "R9 tmr_flag vs model", tmr_flag, {m_tf[1], m_tf[0]});
      chk(ext_flag == {m_ef[1], m_ef[0]}, "R12 ext_flag vs model", ext_flag, {m_ef[1], m_ef[0]});
    end
  end

  task automatic nxt(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    nxt();
    cfg_we = 0;
  endtask

  task automatic ack1();
    cpu_ack = 1; nxt(); cpu_ack = 0;
  endtask

  task automatic reti1();
    cpu_reti = 1; nxt(); cpu_reti = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    nxt(3);
    rst = 0;
    cmp_on = 1;
    nxt();
    // R1 reset state
    chk(irq_req == 0, "R1 irq_req", irq_req, 0);
    chk(ie_rd == 0 && ip_rd == 0, "R1 registers", {ie_rd, ip_rd}, 0);
    chk(act_level == 0, "R1 act_level", act_level, 0);
    chk(tmr_flag == 0 && ext_flag == 0, "R1 flags", {tmr_flag, ext_flag}, 0);

    // R2 register fields
    wr(0, 8'hFF); chk(ie_rd == 8'hBF, "R2 enable bit6", ie_rd, 8'hBF);
    wr(1, 8'hFF); chk(ip_rd == 8'h3F, "R2 priority top bits", ip_rd, 8'h3F);
    wr(1, 8'h00);

    // R3 global enable gate
    wr(0, 8'h3F);
    t2_ovf = 1;
    nxt(3);
    chk(irq_req == 0, "R3 global enable off", irq_req, 0);
    wr(0, 8'hBF);
    nxt();
    chk(irq_req == 1 && irq_idx == 5, "R10 timer2 overflow request", {irq_req, irq_idx}, {1'b1, 3'd5});
    // R7 held while enable withdrawn
    wr(0, 8'h9F);
    nxt(2);
    chk(irq_req == 1 && irq_idx == 5, "R7 held after disable", {irq_req, irq_idx}, {1'b1, 3'd5});
    t2_ovf = 0;
    ack1();
    chk(irq_req == 0 && act_level == 2'b01, "R7 ack marks low level", {irq_req, act_level}, 3'b001);
    reti1();
    chk(act_level == 0, "R8 return clears low", act_level, 0);
    wr(0, 8'hBF);

    // R9 polling skew timer0 vs timer2
    tmr_pulse = 2'b01; t2_evt = 1;
    nxt();
    tmr_pulse = 0;
    chk(tmr_flag[0] == 1, "R9 timer0 flag next cycle", tmr_flag[0], 1);
    chk(irq_req == 1 && irq_idx == 5, "R9 timer2 polled first", irq_idx, 5);
    t2_evt = 0;
    ack1();
    nxt(2);
    chk(irq_req == 0, "R6 low pending blocked by low service", irq_req, 0);
    reti1();
    nxt();
    chk(irq_req == 1 && irq_idx == 1, "R9 timer0 presented", irq_idx, 1);
    chk(irq_vec == 16'h000B, "R13 vector of index 1", irq_vec, 16'h000B);
    ack1();
    chk(tmr_flag[0] == 0, "R11 timer0 flag cleared", tmr_flag[0], 0);
    reti1();

    // R4 order within a level
    ext_edge = 0; ext_pin = 2'b10; tmr_pulse = 2'b10;
    nxt();
    tmr_pulse = 0;
    nxt();
    chk(irq_req == 1 && irq_idx == 2, "R4 ext1 beats timer1", irq_idx, 2);
    ser_flag = 1;
    ack1();
    wr(1, 8'h20);
    t2_ovf = 1;
    nxt(2);
    chk(irq_req == 1 && irq_idx == 5 && irq_hi == 1, "R6 high preempts low", {irq_hi, irq_idx}, {1'b1, 3'd5});
    t2_ovf = 0;
    ack1();
    chk(act_level == 2'b11, "R6 nested levels", act_level, 2'b11);
    ext_pin = 0;
    reti1();
    chk(act_level == 2'b01, "R8 return clears high first", act_level, 2'b01);
    reti1();
    nxt(2);
    chk(irq_req == 1 && irq_idx == 3, "R4 timer1 before serial", irq_idx, 3);
    ack1();
    chk(tmr_flag[1] == 0, "R11 timer1 flag cleared", tmr_flag[1], 0);
    reti1();
    nxt(2);
    chk(irq_req == 1 && irq_idx == 4, "R4 serial presented", irq_idx, 4);
    ack1();
    reti1();
    nxt(2);
    chk(irq_req == 1 && irq_idx == 4, "R11 serial not cleared", irq_idx, 4);
    ser_flag = 0;
    ack1();
    reti1();
    wr(1, 8'h00);

    // R12 edge mode external 0
    ext_edge = 2'b01; ext_pin = 2'b01;
    nxt(3);
    chk(ext_flag[0] == 1, "R12 edge flag set", ext_flag[0], 1);
    chk(irq_req == 1 && irq_idx == 0 && irq_vec == 16'h0003, "R13 vector of index 0", irq_vec, 16'h0003);
    ack1();
    chk(ext_flag[0] == 0, "R11 edge flag cleared", ext_flag[0], 0);
    reti1();
    nxt(3);
    chk(irq_req == 0, "R12 held pin no new edge", irq_req, 0);
    ext_pin = 0;
    nxt(2);
    ext_edge = 0; ext_pin = 2'b01;
    nxt(2);
    chk(irq_req == 1 && irq_idx == 0 && ext_flag == 0, "R12 level request", {irq_req, ext_flag}, 3'b100);
    ack1();
    reti1();
    nxt(2);
    chk(irq_req == 1 && irq_idx == 0, "R11 level ext not cleared", irq_idx, 0);
    ext_pin = 0;
    ack1();
    reti1();
    nxt(2);

    // R5 high level beats lower index
    wr(0, 8'h3F);
    wr(1, 8'h10);
    ext_pin = 2'b01; ser_flag = 1;
    nxt(2);
    wr(0, 8'hBF);
    nxt();
    chk(irq_req == 1 && irq_idx == 4 && irq_hi == 1, "R5 high serial beats ext0", {irq_hi, irq_idx}, {1'b1, 3'd4});
    ser_flag = 0; ext_pin = 0;
    ack1();
    reti1();
    wr(1, 8'h00);
    nxt(2);

    // R8 return with nothing in service
    reti1();
    chk(act_level == 0, "R8 idle return ignored", act_level, 0);
    nxt(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule